// File: doc/BRIEF.md
# Low-Power Stop Recovery Sequencer

This block sequences a processor's exit from a clock-stopped low-power state. On a stop request it captures four configuration bits: the clock source, oscillator-runs-in-stop, PLL enable and the delay select. It then holds the core in a stopped state. If the PLL is enabled and the oscillator does not run during stop, the PLL is powered down.

On a wake request the block derives a stabilization count from the captured bits. It runs that count while it waits for the PLL lock indication when a relock is needed. The lock indication passes through a two-flop synchronizer. Recovery finishes when the later of the two conditions is met. The core-release output then pulses for one cycle and the block returns to normal running.

The long and short delays are parameters (defaults 131072 and 16 cycles). A delay that is not needed counts zero cycles. The analog oscillator, the PLL loop and interrupt routing sit outside the block.

Top module: `stop_recovery_seq`

## Requirements
- R1: After reset `stopped`, `recovering`, `core_release` and `pll_pwrdn` are all 0.
- R2: With the internal oscillator (`cfg_ext_clk`=0), the oscillator off in stop (`cfg_osc_keep`=0) and `cfg_short_dly`=0, the delay is LONG_DLY, so `recovering` stays high for LONG_DLY+1 cycles.
- R3: With the internal oscillator off in stop and `cfg_short_dly`=1, recovery still completes, with `recovering` high for SHORT_DLY+1 cycles.
- R4: With the internal oscillator kept running in stop, the delay is zero and `recovering` lasts 1 cycle whatever `cfg_short_dly` holds.
- R5: With the external clock selected (`cfg_ext_clk`=1), `cfg_short_dly` picks SHORT_DLY (1) or LONG_DLY (0) whether `cfg_osc_keep` is 0 or 1.
- R6: `pll_pwrdn` is 1 while stopped only when `cfg_pll_en`=1 and `cfg_osc_keep`=0 at stop entry. It is 0 in every other state.
- R7: When the PLL was powered down, recovery ends at the later of the count and the synchronized lock. A lock rising in recovery cycle a gives max(delay, a+2)+1 recovery cycles. In all other cases `pll_lock` is ignored.
- R8: Configuration inputs are captured on stop entry. Changing them while stopped or recovering has no effect on the recovery in progress.
- R9: `core_release` is a single-cycle pulse in the cycle after recovery ends. After it, `stopped` and `recovering` are 0.
- R10: `wake_req` has effect only while stopped, and `stop_req` only while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Request to enter the stopped state |
| wake_req | input | 1 | Wake-up event |
| cfg_ext_clk | input | 1 | 1 selects the external clock, 0 the internal oscillator |
| cfg_osc_keep | input | 1 | 1 keeps the oscillator running during stop |
| cfg_pll_en | input | 1 | PLL enabled |
| cfg_short_dly | input | 1 | 1 selects the short stop delay |
| pll_lock | input | 1 | Asynchronous lock indication from the PLL |
| pll_pwrdn | output | 1 | Power-down request to the PLL |
| stopped | output | 1 | Core held in the stopped state |
| recovering | output | 1 | Recovery in progress |
| core_release | output | 1 | One-cycle pulse releasing the core |

## Verification
On every cycle the assertions check the following. The PLL power-down appears only in the stopped state. The release pulse is one cycle long and is followed by running. Recovery never completes while the count is nonzero, or while a needed lock is still low at the synchronizer output. The captured configuration stays fixed outside the running state. Only the bench scenarios can show the exact recovery length for each combination of the decision matrix. They also show the max-of-two behaviour for a late lock against a late count, and that configuration changes made during stop leave the recovery length unchanged.

// File: rtl/stop_recovery_seq.sv
module stop_recovery_seq #(
  parameter int LONG_DLY  = 131072,
  parameter int SHORT_DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wake_req,
  input  logic cfg_ext_clk,
  input  logic cfg_osc_keep,
  input  logic cfg_pll_en,
  input  logic cfg_short_dly,
  input  logic pll_lock,
  output logic pll_pwrdn,
  output logic stopped,
  output logic recovering,
  output logic core_release
);
  localparam int MAXD = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
  localparam int CW   = $clog2(MAXD + 1);

  typedef enum logic [1:0] {S_RUN, S_STOP, S_RECOVER, S_DONE} st_t;

  st_t           st;
  logic          ext_q, keep_q, pll_q, short_q;
  logic [CW-1:0] cnt;
  logic          lock_s1, lock_s2;
  logic [CW-1:0] dly_sel;
  logic          need_lock, finish;

  assign need_lock = pll_q & ~keep_q;
  assign dly_sel   = (!ext_q && keep_q) ? '0 :
                     (short_q ? CW'(SHORT_DLY) : CW'(LONG_DLY));
  assign finish    = (cnt == '0) && (!need_lock || lock_s2);

  assign stopped      = (st == S_STOP);
  assign recovering   = (st == S_RECOVER);
  assign core_release = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_s1 <= 1'b0;
      lock_s2 <= 1'b0;
    end else begin
      lock_s1 <= pll_lock;
      lock_s2 <= lock_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      ext_q     <= 1'b0;
      keep_q    <= 1'b0;
      pll_q     <= 1'b0;
      short_q   <= 1'b0;
      cnt       <= '0;
      pll_pwrdn <= 1'b0;
    end else begin
      case (st)
        S_RUN: if (stop_req) begin
          st        <= S_STOP;
          ext_q     <= cfg_ext_clk;
          keep_q    <= cfg_osc_keep;
          pll_q     <= cfg_pll_en;
          short_q   <= cfg_short_dly;
          pll_pwrdn <= cfg_pll_en & ~cfg_osc_keep;
        end
        S_STOP: if (wake_req) begin
          st        <= S_RECOVER;
          cnt       <= dly_sel;
          pll_pwrdn <= 1'b0;
        end
        S_RECOVER: begin
          if (cnt != '0) cnt <= cnt - CW'(1);
          if (finish) st <= S_DONE;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  // R6
  pwrdn_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_pwrdn |-> stopped);

  // R9
  release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_release |=> (!core_release && !stopped && !recovering));

  // R7
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recovering && need_lock && !lock_s2) |=> !core_release);

  // R2
  count_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recovering && cnt != '0) |=> !core_release);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped || recovering) |=> $stable({ext_q, keep_q, pll_q, short_q}));

  // R10
  wake_only_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recovering) |-> $past(stopped));
endmodule

// File: tb/stop_recovery_seq_bench.sv
module stop_recovery_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, wake_req = 1'b0;
  logic cfg_ext_clk = 1'b0, cfg_osc_keep = 1'b0, cfg_pll_en = 1'b0, cfg_short_dly = 1'b0;
  logic pll_lock = 1'b1;
  logic pll_pwrdn, stopped, recovering, core_release;

  int n_checks = 0;
  int n_errors = 0;
  int exp_q[$];
  int run_len = 0;
  bit pwr_in_rec = 1'b0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  stop_recovery_seq #(.LONG_DLY(40), .SHORT_DLY(5)) u_stop_recovery_seq (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_req(wake_req),
    .cfg_ext_clk(cfg_ext_clk), .cfg_osc_keep(cfg_osc_keep), .cfg_pll_en(cfg_pll_en),
    .cfg_short_dly(cfg_short_dly), .pll_lock(pll_lock), .pll_pwrdn(pll_pwrdn),
    .stopped(stopped), .recovering(recovering), .core_release(core_release));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (recovering) begin
        run_len++;
        if (pll_pwrdn) pwr_in_rec = 1'b1;
      end
      if (core_release) begin
        if (exp_q.size() == 0) check("R9 unexpected release", 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check("R2-R7 recovery length", run_len, e);
          check("R6 pwrdn during recover", int'(pwr_in_rec), 0);
        end
        run_len = 0;
        pwr_in_rec = 1'b0;
      end
    end
  end

  task automatic cycle(input bit ext, input bit keep, input bit pll, input bit shrt,
                       input int lock_at, input int exp_len, input bit exp_pwr,
                       input bit change_cfg, input string req);
    @(negedge clk);
    cfg_ext_clk = ext; cfg_osc_keep = keep; cfg_pll_en = pll; cfg_short_dly = shrt;
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    pll_lock = 1'b0;
    check({req, " stopped"}, int'(stopped), 1);
    check("R6 pll_pwrdn in stop", int'(pll_pwrdn), int'(exp_pwr));
    if (change_cfg) begin
      cfg_ext_clk = ~ext; cfg_osc_keep = ~keep; cfg_pll_en = ~pll; cfg_short_dly = ~shrt;
    end
    repeat (3) @(negedge clk);
    wake_req = 1'b1;
    exp_q.push_back(exp_len);
    @(negedge clk);
    wake_req = 1'b0;
    if (lock_at >= 0) begin
      repeat (lock_at) @(negedge clk);
      pll_lock = 1'b1;
    end
    while (!core_release) @(negedge clk);
    @(negedge clk);
    check("R9 idle after release", int'({stopped, recovering, core_release}), 0);
    pll_lock = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", int'({stopped, recovering, core_release, pll_pwrdn}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release of reset", int'({stopped, recovering, core_release, pll_pwrdn}), 0);
    cycle(0, 0, 0, 0, -1, 41, 0, 0, "R2");
    cycle(0, 0, 0, 1, -1, 6, 0, 0, "R3");
    cycle(0, 1, 0, 1, -1, 1, 0, 0, "R4");
    cycle(0, 1, 0, 0, -1, 1, 0, 0, "R4");
    cycle(1, 1, 0, 0, -1, 41, 0, 0, "R5");
    cycle(1, 0, 0, 1, -1, 6, 0, 0, "R5");
    cycle(0, 0, 1, 0, 60, 63, 1, 0, "R7 late lock");
    cycle(1, 0, 1, 1, 0, 6, 1, 0, "R7 early lock");
    cycle(0, 0, 1, 0, 10, 41, 1, 0, "R7 count later");
    cycle(0, 1, 1, 0, -1, 1, 0, 0, "R7 lock ignored");
    cycle(0, 0, 0, 0, -1, 41, 0, 1, "R8");
    // R10: wake while running must not start a recovery
    @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 wake ignored in run", int'({stopped, recovering, core_release}), 0);
    check("R8 queue drained", exp_q.size(), 0);
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule